// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides, at each instruction boundary, whether a pending interrupt request may be taken. It serves a CPU that allows nested interrupt service with four programmable priority levels. Each maskable source drives a level-sensitive request line and a 2-bit level. Level 0 is the most urgent and level 3 the least. A software request line sits beside the maskable sources. The block owns three pieces of state: the global enable flag, a coarse 2-bit in-service code, and a short stack that saves this context every time an interrupt is taken.

The CPU drives the block with single-cycle command strobes: enable, disable, instruction boundary and return-from-interrupt. The block answers with a one-cycle acknowledge pulse that names the winner. Request lines have no back-pressure. A request that is not taken simply stays pending until its source drops it. After a return, one more instruction of the interrupted program must run before any new interrupt is taken.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset, ack_o is 0, ie_o is 0 and isp_o is 2'b11 (idle), and the context stack is empty.
- R2: An ei_i strobe sets ie_o and a di_i strobe clears it, in the cycle after the strobe, when no acknowledge or return happens in the same cycle.
- R3: ack_o is high for exactly one cycle, the cycle after a sampled boundary_i strobe, and ack_idx_o holds the winning source in that cycle. Each strobe cycle yields at most one acknowledge.
- R4: A maskable request is acknowledged only while ie_o is 1. A blocked request stays pending and is acknowledged at a later strobe once it is allowed.
- R5: Nesting follows the in-service code. Code 11 (idle) and code 10 (level 3 in service) admit levels 0 to 3. Code 01 (level 2 in service) admits levels 0 to 2. Code 00 admits only level 0, because this code stands for both level 0 and level 1.
- R6: Among the eligible maskable requests, the lowest level number wins. Within a level, the lowest source index wins. Source i takes its level from prio_i[2i+1:2i].
- R7: A software request is acknowledged whatever ie_o and isp_o are, and it beats all maskable requests. It is reported with ack_swi_o=1 and ack_idx_o=0, and it sets isp_o to 11. As a result, any enabled maskable level can then nest on top of it.
- R8: On any acknowledge, ie_o becomes 0 and the prior {ie, isp} context is pushed. For a maskable acknowledge, isp_o becomes 00 for level 0 or 1, 01 for level 2 and 10 for level 3.
- R9: A reti_i strobe pops the last pushed context and restores ie_o and isp_o from it. It takes precedence over a boundary strobe in the same cycle. A reti_i with an empty stack changes nothing.
- R10: After a return, the next boundary strobe acknowledges nothing, and the strobe after that may acknowledge.
- R11: While the stack holds DEPTH (5) contexts, no request is acknowledged, software requests included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N | Maskable request lines, level sensitive |
| prio_i | input | 2*N | Level of each source, 2 bits per source |
| swi_req_i | input | 1 | Software interrupt request |
| ei_i | input | 1 | Enable command strobe |
| di_i | input | 1 | Disable command strobe |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_swi_o | output | 1 | Acknowledge is for the software request |
| ack_idx_o | output | $clog2(N) | Index of the acknowledged maskable source |
| ie_o | output | 1 | Global enable flag |
| isp_o | output | 2 | In-service code |

## Verification
The checker watches every cycle for the local rules of an acknowledge: that it follows a strobe, that a maskable win needed the enable flag, that the winner's level was admitted under the previous in-service code, that the new code matches the level, and that no acknowledge comes in the cycle after a return. Other behaviour only shows up over a sequence of commands, so it is left to the bench scenarios. This covers whether a blocked request is still served later, the restore order of nested contexts, the two-strobe gap after a return, the full-stack refusal, and which of several requests wins.

// File: rtl/nia_pkg.sv
`timescale 1ns/1ps
package nia_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t ISP_IDLE = 2'b11;
  localparam lvl_t ISP_L3   = 2'b10;
  localparam lvl_t ISP_L2   = 2'b01;
  localparam lvl_t ISP_L01  = 2'b00;

  typedef struct packed {
    logic ie;
    lvl_t isp;
  } ctx_t;

  // In-service code written when a maskable request of level lvl is taken.
  function automatic lvl_t isp_code(input lvl_t lvl);
    case (lvl)
      2'd3:    return ISP_L3;
      2'd2:    return ISP_L2;
      default: return ISP_L01;
    endcase
  endfunction

  // True when a request of level lvl may nest over in-service code isp.
  function automatic logic lvl_allowed(input lvl_t lvl, input lvl_t isp);
    case (isp)
      ISP_L2:  return (lvl != 2'd3);
      ISP_L01: return (lvl == 2'd0);
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/nia_select.sv
`timescale 1ns/1ps
module nia_select
  import nia_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]   req,
  input  logic [2*N-1:0] prio,
  input  logic           ie,
  input  lvl_t           isp,
  output logic           hit,
  output logic [IW-1:0]  idx,
  output lvl_t           lvl
);
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = req[g] & ie & lvl_allowed(prio[2*g +: 2], isp);
  end

  // Strict compare keeps the lowest index on equal levels.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = 2'd3;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!hit || (prio[2*i +: 2] < lvl))) begin
        hit = 1'b1;
        idx = IW'(i);
        lvl = prio[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/nia_stack.sv
`timescale 1ns/1ps
module nia_stack
  import nia_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  ctx_t din,
  output ctx_t dout,
  output logic full,
  output logic empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt;
  ctx_t          mem [DEPTH];

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = empty ? ctx_t'({1'b0, ISP_IDLE}) : mem[AW'(cnt - CW'(1))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (push && !full)  cnt <= cnt + CW'(1);
    else if (pop && !empty)  cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[AW'(cnt)] <= din;
  end
endmodule

// File: rtl/nest_irq_arbiter.sv
`timescale 1ns/1ps
module nest_irq_arbiter
  import nia_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 5,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_i,
  input  logic [2*N-1:0] prio_i,
  input  logic           swi_req_i,
  input  logic           ei_i,
  input  logic           di_i,
  input  logic           boundary_i,
  input  logic           reti_i,
  output logic           ack_o,
  output logic           ack_swi_o,
  output logic [IW-1:0]  ack_idx_o,
  output logic           ie_o,
  output logic [1:0]     isp_o
);
  logic          ie_q, gap_q;
  lvl_t          isp_q;
  logic          sel_hit;
  logic [IW-1:0] sel_idx;
  lvl_t          sel_lvl;
  logic          stk_full, stk_empty, do_pop, take;
  ctx_t          stk_top;

  nia_select #(.N(N), .IW(IW)) u_sel (
    .req (req_i), .prio(prio_i), .ie(ie_q), .isp(isp_q),
    .hit (sel_hit), .idx(sel_idx), .lvl(sel_lvl)
  );

  assign do_pop = reti_i && !stk_empty;
  assign take   = boundary_i && !reti_i && !gap_q && !stk_full
                  && (swi_req_i || sel_hit);

  nia_stack #(.DEPTH(DEPTH)) u_stk (
    .clk  (clk), .rst_n(rst_n),
    .push (take), .pop(do_pop),
    .din  ({ie_q, isp_q}), .dout(stk_top),
    .full (stk_full), .empty(stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      isp_q     <= ISP_IDLE;
      gap_q     <= 1'b0;
      ack_o     <= 1'b0;
      ack_swi_o <= 1'b0;
      ack_idx_o <= '0;
    end else begin
      ack_o     <= take;
      ack_swi_o <= take && swi_req_i;
      if (take) ack_idx_o <= swi_req_i ? '0 : sel_idx;

      if (do_pop)          gap_q <= 1'b1;
      else if (boundary_i) gap_q <= 1'b0;

      if (do_pop) begin
        ie_q  <= stk_top.ie;
        isp_q <= stk_top.isp;
      end else if (take) begin
        ie_q  <= 1'b0;
        isp_q <= swi_req_i ? ISP_IDLE : isp_code(sel_lvl);
      end else if (ei_i) begin
        ie_q <= 1'b1;
      end else if (di_i) begin
        ie_q <= 1'b0;
      end
    end
  end

  assign ie_o  = ie_q;
  assign isp_o = isp_q;
endmodule

// File: rtl/nia_checker.sv
`timescale 1ns/1ps
module nia_checker
  import nia_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*N-1:0] prio_i,
  input logic           boundary_i,
  input logic           reti_i,
  input logic           ack_o,
  input logic           ack_swi_o,
  input logic [IW-1:0]  ack_idx_o,
  input logic           ie_o,
  input logic [1:0]     isp_o
);
  logic [2*N-1:0] prio_prev;
  lvl_t           won_lvl;

  always_ff @(posedge clk) prio_prev <= prio_i;
  assign won_lvl = prio_prev[2*ack_idx_o +: 2];

  p_ack_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(boundary_i));

  p_ack_clears_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !ie_o);

  p_mask_needs_ie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_swi_o) |-> $past(ie_o));

  p_nest_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_swi_o) |-> lvl_allowed(won_lvl, $past(isp_o)));

  p_isp_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_swi_o) |-> (isp_o == isp_code(won_lvl)));

  p_swi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_swi_o |-> (ack_o && isp_o == ISP_IDLE && ack_idx_o == '0));

  p_reti_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !ack_o);
endmodule

bind nest_irq_arbiter nia_checker #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prio_i(prio_i), .boundary_i(boundary_i),
  .reti_i(reti_i), .ack_o(ack_o), .ack_swi_o(ack_swi_o),
  .ack_idx_o(ack_idx_o), .ie_o(ie_o), .isp_o(isp_o)
);

// File: tb/tb_nest_irq_arbiter.sv
`timescale 1ns/1ps
module tb_nest_irq_arbiter;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [15:0] prio = '1;
  logic        swi = 0, ei = 0, di = 0, bnd = 0, reti = 0;
  logic        ack, ack_swi, ie;
  logic [2:0]  idx;
  logic [1:0]  isp;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nest_irq_arbiter #(.N(N), .DEPTH(5)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .swi_req_i(swi),
    .ei_i(ei), .di_i(di), .boundary_i(bnd), .reti_i(reti),
    .ack_o(ack), .ack_swi_o(ack_swi), .ack_idx_o(idx), .ie_o(ie), .isp_o(isp)
  );

  // {req, prio, swi, exp_ack, exp_swi, exp_idx, exp_isp}; fresh reset + enable each
  localparam logic [31:0] VEC [7] = '{
    {8'h01, 16'hFFFF, 1'b0, 1'b1, 1'b0, 3'd0, 2'b10},
    {8'h80, 16'h3FFF, 1'b0, 1'b1, 1'b0, 3'd7, 2'b00},
    {8'h24, 16'hF7EF, 1'b0, 1'b1, 1'b0, 3'd5, 2'b00},
    {8'h0A, 16'hFFBB, 1'b0, 1'b1, 1'b0, 3'd1, 2'b01},
    {8'hFF, 16'hDDFF, 1'b0, 1'b1, 1'b0, 3'd4, 2'b00},
    {8'h00, 16'hFFFF, 1'b0, 1'b0, 1'b0, 3'd0, 2'b11},
    {8'h03, 16'hFFFF, 1'b1, 1'b1, 1'b1, 3'd0, 2'b11}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req = '0; prio = '1; swi = 0; ei = 0; di = 0; bnd = 0; reti = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) bnd = 1;
    @(negedge clk) bnd = 0;
  endtask

  task automatic cmd_ei();
    @(negedge clk) ei = 1;
    @(negedge clk) ei = 0;
  endtask

  task automatic cmd_di();
    @(negedge clk) di = 1;
    @(negedge clk) di = 0;
  endtask

  task automatic cmd_reti();
    @(negedge clk) reti = 1;
    @(negedge clk) reti = 0;
  endtask

  task automatic src(input int i, input logic [1:0] l);
    prio[2*i +: 2] = l;
    req[i] = 1'b1;
  endtask

  task automatic expect_ack(input string tag, input int i, input int code);
    strobe();
    chk({tag, " ack"}, ack, 1);
    chk({tag, " idx"}, idx, i);
    chk({tag, " isp"}, isp, code);
    chk({tag, " ie"}, ie, 0);
  endtask

  task automatic expect_none(input string tag);
    strobe();
    chk({tag, " no ack"}, ack, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Table: R6 winner selection, R7 software precedence, R8 code update
    for (int v = 0; v < 7; v++) begin
      do_reset();
      cmd_ei();
      if (v == 0) chk("R2 ei sets ie", ie, 1);
      req = VEC[v][31:24]; prio = VEC[v][23:8]; swi = VEC[v][7];
      strobe();
      chk("R6 ack", ack, VEC[v][6]);
      chk("R7 swi flag", ack_swi, VEC[v][5]);
      chk("R6 idx", idx, VEC[v][4:2]);
      chk("R8 isp", isp, VEC[v][1:0]);
      chk("R8 ie", ie, !VEC[v][6]);
      req = '0; swi = 0;
    end

    // R1 reset state, R4 blocked request held pending, R3 pulse width
    do_reset();
    chk("R1 ack", ack, 0);
    chk("R1 ie", ie, 0);
    chk("R1 isp", isp, 3);
    src(3, 2'd2);
    expect_none("R4 ie clear");
    cmd_ei();
    expect_ack("R4 pending taken", 3, 1);
    @(negedge clk);
    chk("R3 one-cycle pulse", ack, 0);
    req = '0;
    cmd_ei();
    cmd_di();
    chk("R2 di clears ie", ie, 0);

    // R5 nesting, R11 full stack, R9 restore, R10 gap
    do_reset();
    cmd_ei(); src(2, 2'd3); expect_ack("R5 idle L3", 2, 2); req = '0;
    cmd_ei(); src(5, 2'd3); expect_ack("R5 equal L3", 5, 2); req = '0;
    cmd_ei(); src(1, 2'd2); expect_ack("R5 L2 over L3", 1, 1); req = '0;
    cmd_ei(); src(4, 2'd3); expect_none("R5 L3 under L2");
    src(4, 2'd1); expect_ack("R5 L1 over L2", 4, 0); req = '0;
    cmd_ei(); src(6, 2'd1); expect_none("R5 L1 under merged code");
    src(0, 2'd0); expect_ack("R5 L0 over merged code", 0, 0); req[0] = 1'b0;
    cmd_ei(); swi = 1; expect_none("R11 stack full"); swi = 0;
    cmd_reti();
    chk("R9 pop1 ie", ie, 1);
    chk("R9 pop1 isp", isp, 0);
    cmd_reti();
    chk("R9 pop2 isp", isp, 1);
    expect_none("R10 gap after return");
    expect_ack("R10 taken after gap", 6, 0); req = '0;
    repeat (4) cmd_reti();
    chk("R9 unwound ie", ie, 1);
    chk("R9 unwound isp", isp, 3);
    cmd_reti();
    chk("R9 empty pop ie", ie, 1);
    chk("R9 empty pop isp", isp, 3);

    // R7 software request ignores ie and level, then any level nests
    do_reset();
    cmd_ei(); src(7, 2'd3); expect_ack("R7 setup", 7, 2); req = '0;
    swi = 1; strobe();
    chk("R7 swi ack", ack, 1);
    chk("R7 swi flag", ack_swi, 1);
    chk("R7 swi isp", isp, 3);
    swi = 0;
    cmd_ei(); src(3, 2'd3); expect_ack("R7 L3 over software", 3, 2); req = '0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule